// File: doc/BRIEF.md
# Zoomable Pixel-to-Complex Coordinate Mapper

This block turns the column and row index of a 64-by-64 image into a signed fixed-point point on the complex plane. A downstream fractal iterator uses that point. The view is held as three registers: a real-axis centre, an imaginary-axis centre and a power-of-two scale. Because the view is centre-and-scale, each coordinate needs only a shift and an add. No division over the pixel span is needed when the view changes.

Single-cycle button pulses move the view. They are assumed to be debounced before they arrive. Pan pulses move a centre by four pixel widths at the current zoom level, so panning speed tracks magnification. Zoom pulses halve or double the scale, within fixed limits. Each pixel request carries a valid strobe. The mapped coordinate comes out one clock later with its own valid strobe.

Top module: `pixel_view_mapper`

## Requirements
- R1: After reset, both centres are zero, the scale is 2^-4 (exponent 16), `coordValid` is low and both coordinate outputs are zero.
- R2: Coordinates are 24-bit two's complement with 20 fraction bits. Each coordinate is computed as centre + (index − 32) × 2^exponent, wrapping modulo 2^24. Real uses `pixX` and imaginary uses `pixY`. From reset, index 0 maps to −2.0 (0xE00000), index 32 maps to 0 and index 63 maps to +1.9375 (0x1F0000).
- R3: A request with `pixValid` high produces `coordValid` high on the next clock. The coordinate is taken from the inputs and view state at that same edge. A cycle with `pixValid` low produces `coordValid` low on the next clock.
- R4: While `pixValid` is low, both coordinate outputs hold their last value, whatever `pixX` and `pixY` do.
- R5: The pan pulses act on the next clock, each moving a centre by 4 × 2^exponent. `btnRight` adds to the real centre and `btnLeft` subtracts from it. `btnUp` adds to the imaginary centre and `btnDown` subtracts from it.
- R6: If both pan pulses of one axis arrive in the same cycle, that axis centre stays unchanged.
- R7: `btnZoomIn` lowers the exponent by one, halving the scale. `btnZoomOut` raises it by one, doubling the scale. If both arrive together, the exponent stays unchanged.
- R8: The exponent is clamped to the range 0 to 18. A zoom-in at 0 and a zoom-out at 18 leave it unchanged.
- R9: If a pan pulse and a zoom pulse arrive in the same cycle, the pan step uses the scale from before the zoom.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pixValid | input | 1 | Pixel request strobe |
| pixX | input | 6 | Pixel column, 0..63 |
| pixY | input | 6 | Pixel row, 0..63 |
| btnUp | input | 1 | Pan up pulse |
| btnDown | input | 1 | Pan down pulse |
| btnLeft | input | 1 | Pan left pulse |
| btnRight | input | 1 | Pan right pulse |
| btnZoomIn | input | 1 | Zoom-in pulse (halve scale) |
| btnZoomOut | input | 1 | Zoom-out pulse (double scale) |
| coordValid | output | 1 | Coordinate valid, one cycle after the request |
| coordRe | output | 24 | Real coordinate, Q3.20 |
| coordIm | output | 24 | Imaginary coordinate, Q3.20 |

## Verification
The mapping is tried in four kinds of view: the reset view, a panned view, a zoomed view and a view at each clamp limit.

- **Pixel patterns.** Requests use the corner indices 0 and 63, the centre index 32 and an odd interior index. These patterns separate a wrong centring offset from a wrong shift and from swapped axes.
- **Single pulses.** Each pulse is applied alone, which checks its direction and step size.
- **Paired pulses.** Opposing pulses arrive together to test cancellation. A pan and a zoom arrive together to show which scale the pan step uses.
- **Hold behaviour.** Indices change while `pixValid` is low, which shows whether the outputs hold.

// File: rtl/pixel_view_pkg.sv
package pixel_view_pkg;
  localparam int AXIS_RE = 0;
  localparam int AXIS_IM = 1;

  // Cleaned pan strobes, one bit per axis (bit 0 real, bit 1 imaginary)
  typedef struct packed {
    logic [1:0] inc;
    logic [1:0] dec;
  } panStrobe_t;
endpackage

// File: rtl/view_control.sv
module view_control
  import pixel_view_pkg::*;
#(
  parameter int EXP_W     = 5,
  parameter int MAX_EXP   = 18,
  parameter int RESET_EXP = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btnUp,
  input  logic             btnDown,
  input  logic             btnLeft,
  input  logic             btnRight,
  input  logic             btnZoomIn,
  input  logic             btnZoomOut,
  output panStrobe_t       strobe,
  output logic [EXP_W-1:0] scaleExp
);
  logic zoomDown;
  logic zoomUp;

  always_comb begin
    strobe.inc[AXIS_RE] = btnRight & ~btnLeft;
    strobe.dec[AXIS_RE] = btnLeft  & ~btnRight;
    strobe.inc[AXIS_IM] = btnUp    & ~btnDown;
    strobe.dec[AXIS_IM] = btnDown  & ~btnUp;
  end

  assign zoomDown = btnZoomIn  & ~btnZoomOut & (scaleExp != '0);
  assign zoomUp   = btnZoomOut & ~btnZoomIn  & (scaleExp != EXP_W'(MAX_EXP));

  always_ff @(posedge clk) begin
    if (rst)           scaleExp <= EXP_W'(RESET_EXP);
    else if (zoomDown) scaleExp <= scaleExp - 1'b1;
    else if (zoomUp)   scaleExp <= scaleExp + 1'b1;
  end

  AST_EXP_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    scaleExp <= EXP_W'(MAX_EXP)); // R8
  AST_ZOOM_IN_HALVES: assert property (@(posedge clk) disable iff (rst)
    (btnZoomIn && !btnZoomOut && scaleExp != '0) |=> scaleExp == EXP_W'($past(scaleExp) - 1'b1)); // R7
  AST_ZOOM_LOW_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (btnZoomIn && scaleExp == '0) |=> scaleExp == '0); // R8
  AST_ZOOM_HIGH_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (btnZoomOut && scaleExp == EXP_W'(MAX_EXP)) |=> scaleExp == EXP_W'(MAX_EXP)); // R8
  AST_ZOOM_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (btnZoomIn && btnZoomOut) |=> $stable(scaleExp)); // R7
endmodule

// File: rtl/coord_datapath.sv
module coord_datapath
  import pixel_view_pkg::*;
#(
  parameter int PIX_W     = 6,
  parameter int COORD_W   = 24,
  parameter int EXP_W     = 5,
  parameter int PAN_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  panStrobe_t         strobe,
  input  logic [EXP_W-1:0]   scaleExp,
  input  logic               pixValid,
  input  logic [PIX_W-1:0]   pixX,
  input  logic [PIX_W-1:0]   pixY,
  output logic               coordValid,
  output logic [COORD_W-1:0] coordRe,
  output logic [COORD_W-1:0] coordIm
);
  localparam int CENTER = 2 ** (PIX_W - 1);

  logic [PIX_W-1:0]   pixIdx [2];
  logic [COORD_W-1:0] origin [2];
  logic [COORD_W-1:0] coord  [2];
  logic [COORD_W-1:0] panStep;

  assign pixIdx[AXIS_RE] = pixX;
  assign pixIdx[AXIS_IM] = pixY;
  assign panStep = (COORD_W'(1) << scaleExp) << PAN_SHIFT;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    logic signed [PIX_W:0] centred;
    logic [COORD_W-1:0]    offset;

    assign centred = $signed({1'b0, pixIdx[a]}) - $signed((PIX_W + 1)'(CENTER));
    assign offset  = COORD_W'(centred) << scaleExp;

    always_ff @(posedge clk) begin
      if (rst)                origin[a] <= '0;
      else if (strobe.inc[a]) origin[a] <= origin[a] + panStep;
      else if (strobe.dec[a]) origin[a] <= origin[a] - panStep;
    end

    always_ff @(posedge clk) begin
      if (rst)           coord[a] <= '0;
      else if (pixValid) coord[a] <= origin[a] + offset;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) coordValid <= 1'b0;
    else     coordValid <= pixValid;
  end

  assign coordRe = coord[AXIS_RE];
  assign coordIm = coord[AXIS_IM];

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(strobe.inc[AXIS_RE] && strobe.dec[AXIS_RE]) && !(strobe.inc[AXIS_IM] && strobe.dec[AXIS_IM])); // R6
  AST_RE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!strobe.inc[AXIS_RE] && !strobe.dec[AXIS_RE]) |=> $stable(origin[AXIS_RE])); // R6
  AST_IM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!strobe.inc[AXIS_IM] && !strobe.dec[AXIS_IM]) |=> $stable(origin[AXIS_IM])); // R6
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    pixValid |=> coordValid); // R3
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (rst)
    !pixValid |=> !coordValid); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pixValid |=> ($stable(coordRe) && $stable(coordIm))); // R4
endmodule

// File: rtl/pixel_view_mapper.sv
module pixel_view_mapper
  import pixel_view_pkg::*;
#(
  parameter int PIX_W     = 6,
  parameter int COORD_W   = 24,
  parameter int FRAC_W    = 20,
  parameter int PAN_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pixValid,
  input  logic [PIX_W-1:0]   pixX,
  input  logic [PIX_W-1:0]   pixY,
  input  logic               btnUp,
  input  logic               btnDown,
  input  logic               btnLeft,
  input  logic               btnRight,
  input  logic               btnZoomIn,
  input  logic               btnZoomOut,
  output logic               coordValid,
  output logic [COORD_W-1:0] coordRe,
  output logic [COORD_W-1:0] coordIm
);
  // Reset view spans 4.0 units across the image; largest scale keeps offsets in range
  localparam int RESET_EXP = FRAC_W + 2 - PIX_W;
  localparam int MAX_EXP   = COORD_W - PIX_W;
  localparam int EXP_W     = $clog2(MAX_EXP + 1);

  panStrobe_t       strobe;
  logic [EXP_W-1:0] scaleExp;

  view_control #(
    .EXP_W(EXP_W), .MAX_EXP(MAX_EXP), .RESET_EXP(RESET_EXP)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .btnUp(btnUp), .btnDown(btnDown), .btnLeft(btnLeft), .btnRight(btnRight),
    .btnZoomIn(btnZoomIn), .btnZoomOut(btnZoomOut),
    .strobe(strobe), .scaleExp(scaleExp)
  );

  coord_datapath #(
    .PIX_W(PIX_W), .COORD_W(COORD_W), .EXP_W(EXP_W), .PAN_SHIFT(PAN_SHIFT)
  ) u_path (
    .clk(clk), .rst(rst), .strobe(strobe), .scaleExp(scaleExp),
    .pixValid(pixValid), .pixX(pixX), .pixY(pixY),
    .coordValid(coordValid), .coordRe(coordRe), .coordIm(coordIm)
  );
endmodule

// File: tb/pixel_view_mapper_test.sv
`timescale 1ns/1ps
module pixel_view_mapper_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pixValid = 1'b0;
  logic [5:0] pixX = '0, pixY = '0;
  logic btnUp = 1'b0, btnDown = 1'b0, btnLeft = 1'b0, btnRight = 1'b0;
  logic btnZoomIn = 1'b0, btnZoomOut = 1'b0;
  logic coordValid;
  logic [23:0] coordRe, coordIm;

  int checks = 0;
  int fails  = 0;
  longint mRe = 0, mIm = 0;
  int mExp = 16;

  always #2.5 clk = ~clk;

  pixel_view_mapper uut (
    .clk(clk), .rst(rst), .pixValid(pixValid), .pixX(pixX), .pixY(pixY),
    .btnUp(btnUp), .btnDown(btnDown), .btnLeft(btnLeft), .btnRight(btnRight),
    .btnZoomIn(btnZoomIn), .btnZoomOut(btnZoomOut),
    .coordValid(coordValid), .coordRe(coordRe), .coordIm(coordIm)
  );

  function automatic logic [23:0] expect_coord(longint org, int idx, int e);
    longint v;
    v = org + longint'(idx - 32) * (64'sd1 <<< e);
    return v[23:0];
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic press(logic u, logic d, logic l, logic r, logic zi, logic zo);
    longint step;
    @(negedge clk);
    btnUp = u; btnDown = d; btnLeft = l; btnRight = r; btnZoomIn = zi; btnZoomOut = zo;
    @(negedge clk);
    btnUp = 0; btnDown = 0; btnLeft = 0; btnRight = 0; btnZoomIn = 0; btnZoomOut = 0;
    step = 64'sd4 <<< mExp;
    if (r && !l) mRe += step;
    if (l && !r) mRe -= step;
    if (u && !d) mIm += step;
    if (d && !u) mIm -= step;
    if (zi && !zo && mExp > 0)  mExp--;
    if (zo && !zi && mExp < 18) mExp++;
  endtask

  task automatic map_pix(string req, int x, int y);
    @(negedge clk);
    pixValid = 1; pixX = 6'(x); pixY = 6'(y);
    @(negedge clk);
    pixValid = 0;
    check({req, " valid"}, longint'(coordValid), 1);
    check({req, " re"}, longint'(coordRe), longint'(expect_coord(mRe, x, mExp)));
    check({req, " im"}, longint'(coordIm), longint'(expect_coord(mIm, y, mExp)));
  endtask

  task automatic t_reset;
    check("R1 valid", longint'(coordValid), 0);
    check("R1 re", longint'(coordRe), 0);
    check("R1 im", longint'(coordIm), 0);
    map_pix("R1 centre", 32, 32);
  endtask

  task automatic t_map;
    map_pix("R2 corner", 0, 63);
    check("R2 minus two", longint'(coordRe), 24'hE00000);
    check("R2 top", longint'(coordIm), 24'h1F0000);
    map_pix("R3 swap", 63, 0);
    map_pix("R2 interior", 32, 17);
  endtask

  task automatic t_hold;
    logic [23:0] re0, im0;
    map_pix("R4 base", 5, 40);
    re0 = coordRe; im0 = coordIm;
    @(negedge clk); pixX = 6'd60; pixY = 6'd1;
    @(negedge clk); @(negedge clk);
    check("R3 valid low", longint'(coordValid), 0);
    check("R4 re hold", longint'(coordRe), longint'(re0));
    check("R4 im hold", longint'(coordIm), longint'(im0));
  endtask

  task automatic t_pan;
    press(0, 0, 0, 1, 0, 0);
    press(0, 0, 0, 1, 0, 0);
    press(1, 0, 0, 0, 0, 0);
    map_pix("R5 right up", 32, 32);
    press(0, 0, 1, 0, 0, 0);
    press(0, 1, 0, 0, 0, 0);
    press(0, 1, 0, 0, 0, 0);
    map_pix("R5 left down", 10, 50);
  endtask

  task automatic t_cancel;
    press(0, 0, 1, 1, 0, 0);
    press(1, 1, 0, 0, 0, 0);
    map_pix("R6 cancel", 32, 32);
  endtask

  task automatic t_zoom;
    press(0, 0, 0, 0, 1, 0);
    map_pix("R7 zoom in", 0, 63);
    press(0, 0, 0, 0, 0, 1);
    press(0, 0, 0, 0, 0, 1);
    map_pix("R7 zoom out", 0, 63);
    press(0, 0, 0, 0, 1, 1);
    map_pix("R7 both", 1, 62);
  endtask

  task automatic t_clamp;
    for (int i = 0; i < 22; i++) press(0, 0, 0, 0, 1, 0);
    map_pix("R8 low clamp", 0, 63);
    for (int i = 0; i < 22; i++) press(0, 0, 0, 0, 0, 1);
    map_pix("R8 high clamp", 0, 63);
    press(0, 0, 0, 0, 1, 0);
    press(0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_combo;
    press(0, 0, 0, 1, 1, 0);
    map_pix("R9 pan then zoom", 32, 32);
    press(1, 0, 0, 0, 0, 1);
    map_pix("R9 pan with zoom out", 20, 32);
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_map;
    t_hold;
    t_pan;
    t_cancel;
    t_zoom;
    t_clamp;
    t_combo;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule